// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the scan timing for a raster monitor from a free-running pixel clock. It drives active-low horizontal and vertical sync pulses and a display-active flag. It also provides two position counters that give the current pixel column and row inside the visible area. A pixel generator downstream uses the flag and the counters to decide which colour to drive, and it forces black whenever the flag is low so that nothing is painted during retrace.

A compile-time parameter picks the timing. Mode 0 is a stretched low-resolution raster: 128 visible dots per line and 255 visible lines, meant for a 10 MHz pixel clock. It has long porches and a vertical sync that lasts three lines. Mode 1 is the common 640x480 raster at about 25 MHz. Each line and each frame starts with its sync pulse, then the back porch, then the visible region, then the front porch. The vertical position advances once per line, on the last clock of the line.

Top module: `vga_raster_gen`

## Requirements
- R1: `rst` is synchronous and active high. In every cycle after a clock edge at which `rst` was high, `hsync_n` and `vsync_n` are 0, `bright` is 0, and `hpos` and `vpos` are 0. The first cycle after reset is released is clock 0 of line 0.
- R2: A line lasts 300 clocks in mode 0 and 800 clocks in mode 1. Clock index c counts 0 to length-1 and then wraps to 0.
- R3: `hsync_n` is 0 for clocks 0 to 19 of each line in mode 0, and for clocks 0 to 95 in mode 1. It is 1 for the rest of the line.
- R4: The horizontal visible window covers clocks 127 to 254 in mode 0 and clocks 144 to 783 in mode 1.
- R5: A frame has 556 lines in mode 0 and 525 lines in mode 1. The line index changes only when clock index c wraps from its last value to 0. A frame therefore starts at a line start.
- R6: `vsync_n` is 0 for whole lines 0 to 2 in mode 0, and for lines 0 to 1 in mode 1. It is 1 on all other lines.
- R7: The vertical visible window covers lines 165 to 419 in mode 0 and lines 35 to 514 in mode 1.
- R8: `bright` is 1 exactly when both the clock index and the line index lie inside their visible windows. It is therefore 0 whenever either sync is low.
- R9: While `bright` is 1, `hpos` equals the clock index minus the first visible clock, and `vpos` equals the line index minus the first visible line. While `bright` is 0, both read 0.
- R10: Parameter `MODE` = 0 selects the 128x255 timing and `MODE` = 1 selects the 640x480 timing. No other pin affects the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| bright | output | 1 | High inside the visible region |
| hpos | output | 10 | Visible column, zero outside the visible region |
| vpos | output | 10 | Visible row, zero outside the visible region |

## Verification
The properties assume that the clock never stops and that `rst` is a clean level sampled at rising edges. The pulse-width checks count from the last reset, so a reset in the middle of a pulse only restarts the count. The bench changes `rst` at falling edges only, holds it across several rising edges, and asserts it once more in the middle of a run. Apart from that, the block sees no input, so the timing checks hold for any legal stimulus.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;

  localparam int POS_W = 10;

  // One scan axis: sync, back porch, visible span, front porch (in ticks)
  typedef struct packed {
    int unsigned sync;
    int unsigned bp;
    int unsigned act;
    int unsigned fp;
  } axis_t;

  function automatic axis_t h_axis(input int mode);
    axis_t a;
    if (mode == 0) a = '{sync: 20, bp: 107, act: 128, fp: 45};
    else           a = '{sync: 96, bp: 48,  act: 640, fp: 16};
    return a;
  endfunction

  function automatic axis_t v_axis(input int mode);
    axis_t a;
    if (mode == 0) a = '{sync: 3, bp: 162, act: 255, fp: 136};
    else           a = '{sync: 2, bp: 33,  act: 480, fp: 10};
    return a;
  endfunction

  function automatic int unsigned axis_total(input axis_t a);
    return a.sync + a.bp + a.act + a.fp;
  endfunction

endpackage

// File: rtl/vga_axis_cnt.sv
module vga_axis_cnt #(
  parameter int SYNC  = 20,
  parameter int BP    = 107,
  parameter int ACT   = 128,
  parameter int FP    = 45,
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic             sync_n,
  output logic             active,
  output logic             last,
  output logic [POS_W-1:0] pos
);
  localparam int TOT    = SYNC + BP + ACT + FP;
  localparam int CW     = $clog2(TOT);
  localparam int ACT_LO = SYNC + BP;
  localparam int ACT_HI = ACT_LO + ACT;

  localparam logic [CW-1:0] LAST_V = CW'(TOT - 1);
  localparam logic [CW-1:0] SYNC_V = CW'(SYNC);
  localparam logic [CW-1:0] LO_V   = CW'(ACT_LO);
  localparam logic [CW-1:0] HI_V   = CW'(ACT_HI);

  logic [CW-1:0] cnt;
  logic [CW-1:0] off;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= last ? '0 : cnt + 1'b1;
  end

  assign last   = (cnt == LAST_V);
  assign sync_n = (cnt >= SYNC_V);
  assign active = (cnt >= LO_V) && (cnt < HI_V);
  assign off    = cnt - LO_V;
  assign pos    = active ? POS_W'(off) : '0;

endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
  import vga_raster_pkg::*;
#(
  parameter int MODE = 0
) (
  input  logic             clk,
  input  logic             rst,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             bright,
  output logic [POS_W-1:0] hpos,
  output logic [POS_W-1:0] vpos
);
  localparam axis_t HA = h_axis(MODE);
  localparam axis_t VA = v_axis(MODE);

  logic             h_act, v_act, h_last, v_last;
  logic [POS_W-1:0] h_pos, v_pos;

  vga_axis_cnt #(
    .SYNC(HA.sync), .BP(HA.bp), .ACT(HA.act), .FP(HA.fp), .POS_W(POS_W)
  ) u_h (
    .clk(clk), .rst(rst), .step(1'b1),
    .sync_n(hsync_n), .active(h_act), .last(h_last), .pos(h_pos)
  );

  vga_axis_cnt #(
    .SYNC(VA.sync), .BP(VA.bp), .ACT(VA.act), .FP(VA.fp), .POS_W(POS_W)
  ) u_v (
    .clk(clk), .rst(rst), .step(h_last),
    .sync_n(vsync_n), .active(v_act), .last(v_last), .pos(v_pos)
  );

  logic unused_v_last;
  assign unused_v_last = v_last;

  assign bright = h_act & v_act;
  assign hpos   = bright ? h_pos : '0;
  assign vpos   = bright ? v_pos : '0;

endmodule

// File: rtl/vga_raster_chk.sv
module vga_raster_chk
  import vga_raster_pkg::*;
#(
  parameter int MODE = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             bright,
  input logic [POS_W-1:0] hpos,
  input logic [POS_W-1:0] vpos
);
  localparam axis_t HA   = h_axis(MODE);
  localparam axis_t VA   = v_axis(MODE);
  localparam int    HTOT = axis_total(HA);
  localparam int    HS   = HA.sync;
  localparam int    VLOW = VA.sync * HTOT;

  logic [15:0] hrun, vrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      hrun <= '0;
      vrun <= '0;
    end else begin
      hrun <= hsync_n ? 16'd0 : hrun + 16'd1;
      vrun <= vsync_n ? 16'd0 : vrun + 16'd1;
    end
  end

  p_reset_start_r1: assert property (@(posedge clk)
    rst |=> (!hsync_n && !vsync_n && !bright && hpos == '0 && vpos == '0));

  p_hsync_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_n) |-> hrun == 16'(HS));

  p_vsync_width_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync_n) |-> vrun == 16'(VLOW));

  p_frame_on_line_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> $fell(hsync_n));

  p_blank_in_sync_r8: assert property (@(posedge clk) disable iff (rst)
    (!hsync_n || !vsync_n) |-> !bright);

  p_dark_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !bright |-> (hpos == '0 && vpos == '0));

  p_hpos_step_r9: assert property (@(posedge clk) disable iff (rst)
    (bright && hpos != '0) |-> ($past(bright) && hpos == $past(hpos) + POS_W'(1)));

  p_vpos_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (bright && $past(bright)) |-> vpos == $past(vpos));

endmodule

bind vga_raster_gen vga_raster_chk #(.MODE(MODE)) u_chk (
  .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .bright(bright), .hpos(hpos), .vpos(vpos)
);

// File: tb/vga_raster_gen_tb.sv
module vga_raster_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       hs0, vs0, br0, hs1, vs1, br1;
  logic [9:0] hp0, vp0, hp1, vp1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  vga_raster_gen #(.MODE(0)) u_dut (
    .clk(clk), .rst(rst), .hsync_n(hs0), .vsync_n(vs0),
    .bright(br0), .hpos(hp0), .vpos(vp0));

  vga_raster_gen #(.MODE(1)) u_dut_std (
    .clk(clk), .rst(rst), .hsync_n(hs1), .vsync_n(vs1),
    .bright(br1), .hpos(hp1), .vpos(vp1));

  task automatic chk(input string req, input int mode, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s mode=%0d actual=%0d expected=%0d at %0t", req, mode, act, exp, $time);
    end
  endtask

  // Arithmetic model of both timings; n = clocks since reset release
  task automatic check_pt(input int mode, input int n, input logic hs, vs, br,
                          input logic [9:0] hp, vp);
    int hsw, hbp, hact, htot, vsw, vbp, vact, vtot, hc, ln, e_br;
    bit ha, va;
    if (mode == 0) begin
      hsw = 20; hbp = 107; hact = 128; htot = 300;
      vsw = 3;  vbp = 162; vact = 255; vtot = 556;
    end else begin
      hsw = 96; hbp = 48; hact = 640; htot = 800;
      vsw = 2;  vbp = 33; vact = 480; vtot = 525;
    end
    hc = n % htot;
    ln = (n / htot) % vtot;
    ha = (hc >= hsw + hbp) && (hc < hsw + hbp + hact);
    va = (ln >= vsw + vbp) && (ln < vsw + vbp + vact);
    e_br = (ha && va) ? 1 : 0;
    chk("R3/R2/R10 hsync_n", mode, int'(hs), (hc >= hsw) ? 1 : 0);
    chk("R6/R5 vsync_n", mode, int'(vs), (ln >= vsw) ? 1 : 0);
    chk("R8/R4/R7 bright", mode, int'(br), e_br);
    chk("R9 hpos", mode, int'(hp), e_br ? hc - (hsw + hbp) : 0);
    chk("R9 vpos", mode, int'(vp), e_br ? ln - (vsw + vbp) : 0);
  endtask

  task automatic check_reset();
    chk("R1 hsync_n", 0, int'(hs0), 0); chk("R1 vsync_n", 0, int'(vs0), 0);
    chk("R1 bright", 0, int'(br0), 0);  chk("R1 hpos", 0, int'(hp0), 0);
    chk("R1 vpos", 0, int'(vp0), 0);
    chk("R1 hsync_n", 1, int'(hs1), 0); chk("R1 vsync_n", 1, int'(vs1), 0);
    chk("R1 bright", 1, int'(br1), 0);  chk("R1 hpos", 1, int'(hp1), 0);
    chk("R1 vpos", 1, int'(vp1), 0);
  endtask

  task automatic run(input int cycles);
    check_pt(0, 0, hs0, vs0, br0, hp0, vp0);
    check_pt(1, 0, hs1, vs1, br1, hp1, vp1);
    for (int n = 1; n <= cycles; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_pt(0, n, hs0, vs0, br0, hp0, vp0);
      check_pt(1, n, hs1, vs1, br1, hp1, vp1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();                 // R1: state while reset is held
    rst = 1'b0;
    run(300 * 556 + 700);          // full short frame plus wrap into next
    rst = 1'b1;                    // R1: mid-run reset
    @(posedge clk);
    @(negedge clk);
    check_reset();
    @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    run(400);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule